// File: doc/BRIEF.md
# Successive Approximation Control Register

This block is the digital half of a successive-approximation ADC. It holds the trial code that drives the DAC and collects the comparator's decisions into the final result. The trial marker and the result live in the same flip-flops. A bit that is 1 below all decided bits marks the bit under trial, so no separate sequencer or step counter is needed. One extra stage below the LSB becomes 1 when the last bit has been decided. That stage is the end-of-conversion flag.

Each stage picks its next value from one of three sources: the stage above it, the comparator, or itself. An OR chain runs upward from the bottom stage. A stage holds whenever any stage below it is set or the stop input is high. This freezes every decided bit, and with stop high it freezes the whole register. A start pulse loads the MSB trial pattern. The surrounding system samples the analog input, drives the DAC from the code output and returns the comparator decision each clock.

Top module: `sar_stop_chain_reg`

## Requirements
- R1: While reset is asserted, and until the first start after reset, code is 0 and eoc is 0.
- R2: The clock edge that samples start high loads code with only bit N-1 set (12'h800 at the default width) and clears eoc. This happens whether or not stop is high.
- R3: On each decision clock, the bit under trial (the lowest set bit of code) takes comp, where 1 keeps it and 0 clears it. On the same edge the bit just below it is set to 1 as the new trial bit.
- R4: During a conversion, bits above the bit under trial never change.
- R5: With stop low, eoc rises on the 12th clock edge after the start edge (N edges in general). At that point code equals the largest value whose DAC level the comparator reports at or below the input. For an ideal comparator (comp = input >= code), that is the input value itself.
- R6: While stop is high and start is low, code and eoc do not change, whatever comp does. When stop falls, the conversion continues from where it was frozen.
- R7: Once eoc is 1, code and eoc keep their values until the next start, whatever comp does.
- R8: A start during a running conversion restarts it from 12'h800, and the new conversion completes normally.
- R9: Outside a conversion (after reset and before any start), comp has no effect on code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a conversion with the MSB trial pattern |
| stop | input | 1 | Freeze all stages while high |
| comp | input | 1 | Comparator decision, 1 = input at or above DAC level |
| code | output | N (12) | Trial code during conversion, result afterwards |
| eoc | output | 1 | End of conversion, from the stage below the LSB |

## Verification
A wrong hold term or select in any stage corrupts the code on the very next decision edge. Either a decided bit changes, or the trial bit fails to move down one position. The bench compares the complete code after every decision clock against a prefix of the input value plus the expected trial bit, so such an error shows up within one clock. A broken link in the stop chain or in the marker stage shows up as eoc arriving early, late or never. It can also show up as code drifting while stop is high or after completion; the bench checks each of these within a few cycles.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;
  // Source of a stage's next value
  typedef enum logic [1:0] {
    SRC_SHIFT = 2'd0,  // take the stage above
    SRC_LOAD  = 2'd1,  // take the comparator decision
    SRC_HOLD  = 2'd2   // keep own value
  } stage_src_t;
endpackage

// File: rtl/sar_rst_sync.sv
module sar_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/sar_hold_chain.sv
module sar_hold_chain #(
  parameter int W = 13
) (
  input  logic         stop,
  input  logic [W-1:0] stage_q,
  output logic [W-1:0] hold
);
  // Ripple from the bottom stage upward: a stage is frozen when stop is
  // high or any stage beneath it is set.
  assign hold[0] = stop;
  for (genvar k = 1; k < W; k++) begin : g_link
    assign hold[k] = hold[k-1] | stage_q[k-1];
  end
endmodule

// File: rtl/sar_stage.sv
module sar_stage
  import sar_ctrl_pkg::*;
#(
  parameter logic INIT_VAL = 1'b0,
  parameter bit   IS_FLAG  = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic hold,
  input  logic from_above,
  input  logic comp,
  output logic q
);
  stage_src_t src;
  logic       d_sel;
  logic       d_next;
  logic       en;
  logic       q_r;

  // Next-state selection
  always_comb begin
    if (hold)          src = SRC_HOLD;
    else if (q_r)      src = IS_FLAG ? SRC_HOLD : SRC_LOAD;
    else               src = SRC_SHIFT;

    unique case (src)
      SRC_SHIFT: d_sel = from_above;
      SRC_LOAD:  d_sel = comp;
      default:   d_sel = q_r;
    endcase

    en     = init | (src != SRC_HOLD);
    d_next = init ? INIT_VAL : d_sel;
  end

  // State register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= 1'b0;
    else if (en) q_r <= d_next;
  end

  assign q = q_r;

  // A frozen stage keeps its value unless start reloads it (R4, R6)
  assert_frozen_stage_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !init) |=> $stable(q_r));
endmodule

// File: rtl/sar_stop_chain_reg.sv
module sar_stop_chain_reg #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         stop,
  input  logic         comp,
  output logic [N-1:0] code,
  output logic         eoc
);
  localparam int W = N + 1;  // N result stages plus the completion stage

  logic         rst_sync_n;
  logic [W-1:0] stage_q;
  logic [W-1:0] hold;
  logic [W-1:0] above;

  sar_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sar_hold_chain #(.W(W)) u_chain (
    .stop    (stop),
    .stage_q (stage_q),
    .hold    (hold)
  );

  assign above = {1'b0, stage_q[W-1:1]};

  for (genvar k = 0; k < W; k++) begin : g_stage
    sar_stage #(
      .INIT_VAL (k == W-1),
      .IS_FLAG  (k == 0)
    ) u_stage (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .init       (start),
      .hold       (hold[k]),
      .from_above (above[k]),
      .comp       (comp),
      .q          (stage_q[k])
    );
  end

  assign code = stage_q[W-1:1];
  assign eoc  = stage_q[0];

  // Start loads the MSB trial pattern, also over stop (R2)
  assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start |=> (code == {1'b1, {(N-1){1'b0}}}) && !eoc);

  // Stop freezes everything (R6)
  assert_stop_freeze_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stop && !start) |=> ($stable(code) && $stable(eoc)));

  // Completed result is kept (R7)
  assert_result_kept_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (eoc && !start) |=> (eoc && $stable(code)));

  // Every free decision clock moves the state forward (R5)
  assert_progress_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!start && !stop && !eoc && (code != '0)) |=> ({code, eoc} != $past({code, eoc})));

  // Idle register ignores the comparator (R9)
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!start && !eoc && (code == '0)) |=> (code == '0) && !eoc);
endmodule

// File: tb/sar_stop_chain_reg_bench.sv
module sar_stop_chain_reg_bench;
  localparam int N = 12;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic         stop;
  logic         comp;
  logic [N-1:0] code;
  logic         eoc;

  int checks = 0;
  int errors = 0;
  int k_done = 0;

  localparam logic [N-1:0] VECS [10] = '{
    12'h000, 12'hFFF, 12'h800, 12'h7FF, 12'h555,
    12'hAAA, 12'h001, 12'hFFE, 12'h3C9, 12'hB17
  };

  always #10 clk = ~clk;

  sar_stop_chain_reg #(.N(N)) u_sar_stop_chain_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .stop  (stop),
    .comp  (comp),
    .code  (code),
    .eoc   (eoc)
  );

  task automatic chk(input logic ok, input string req,
                     input logic [N:0] act, input logic [N:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_code(input logic [N-1:0] vin, input int k);
    logic [N-1:0] top;
    logic [N-1:0] trial;
    top   = (k == 0) ? '0 : (12'hFFF << (N - k));
    trial = (k < N) ? (12'h001 << (N - 1 - k)) : '0;
    return (vin & top) | trial;
  endfunction

  task automatic begin_conv();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    k_done = 0;
    chk(code == 12'h800 && !eoc, "R2", {eoc, code}, {1'b0, 12'h800});
  endtask

  // One decision clock with an ideal comparator, then check the full state (R3, R4)
  task automatic step(input logic [N-1:0] vin);
    comp = (vin >= code);
    @(negedge clk);
    k_done++;
    chk({eoc, code} == {k_done == N, exp_code(vin, k_done)}, "R3/R4 step",
        {eoc, code}, {k_done == N, exp_code(vin, k_done)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; stop = 1'b0; comp = 1'b0;
    repeat (3) @(negedge clk);
    chk(code == '0 && !eoc, "R1 in reset", {eoc, code}, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(code == '0 && !eoc, "R1 after reset", {eoc, code}, '0);

    // R9: comparator toggling while idle
    for (int i = 0; i < 4; i++) begin
      comp = i[0]; @(negedge clk);
      chk(code == '0 && !eoc, "R9 idle", {eoc, code}, '0);
    end

    // Vector table: full conversions, R5 result and latency
    for (int v = 0; v < 10; v++) begin
      begin_conv();
      for (int s = 0; s < N; s++) step(VECS[v]);
      chk(eoc && code == VECS[v] && k_done == N, "R5 result",
          {eoc, code}, {1'b1, VECS[v]});
    end

    // R7: result kept while comp toggles
    for (int i = 0; i < 5; i++) begin
      comp = ~comp; @(negedge clk);
      chk(eoc && code == VECS[9], "R7 hold", {eoc, code}, {1'b1, VECS[9]});
    end

    // R6: stop mid-conversion, then resume
    begin_conv();
    for (int s = 0; s < 4; s++) step(12'h5A3);
    stop = 1'b1;
    for (int i = 0; i < 3; i++) begin
      comp = i[0]; @(negedge clk);
      chk(!eoc && code == exp_code(12'h5A3, 4), "R6 frozen",
          {eoc, code}, {1'b0, exp_code(12'h5A3, 4)});
    end
    stop = 1'b0;
    for (int s = 0; s < 8; s++) step(12'h5A3);
    chk(eoc && code == 12'h5A3, "R6 resumed", {eoc, code}, {1'b1, 12'h5A3});

    // R6: stop right after completion keeps result
    stop = 1'b1; comp = 1'b0;
    @(negedge clk);
    chk(eoc && code == 12'h5A3, "R6 stop after done", {eoc, code}, {1'b1, 12'h5A3});
    stop = 1'b0;

    // R8: restart during a conversion
    begin_conv();
    for (int s = 0; s < 5; s++) step(12'h0F0);
    begin_conv();
    chk(code == 12'h800, "R8 restart", {eoc, code}, {1'b0, 12'h800});
    for (int s = 0; s < N; s++) step(12'hE3D);
    chk(eoc && code == 12'hE3D, "R8 restart result", {eoc, code}, {1'b1, 12'hE3D});

    // R2: start wins over stop, then stop freezes the fresh pattern
    @(negedge clk); start = 1'b1; stop = 1'b1; comp = 1'b0;
    @(negedge clk); start = 1'b0;
    chk(code == 12'h800 && !eoc, "R2 start over stop", {eoc, code}, {1'b0, 12'h800});
    @(negedge clk);
    chk(code == 12'h800 && !eoc, "R6 frozen trial", {eoc, code}, {1'b0, 12'h800});
    stop = 1'b0;
    k_done = 0;
    for (int s = 0; s < N; s++) step(12'h2B4);
    chk(eoc && code == 12'h2B4, "R5 after frozen start", {eoc, code}, {1'b1, 12'h2B4});

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule